// File: doc/BRIEF.md
# Asynchronous serial receiver with aliased framing-error flag

This block receives characters on a single serial input line and exposes them through a small byte-wide register bus. It has three registers: a serial control register, a read-only receive buffer and a power/option register. The line is sampled on a 16x oversampling tick supplied from outside. A bit counts as received when a majority vote of three samples taken near the middle of the bit agrees. Two frame lengths are supported: 10 bits for the 8-bit asynchronous mode, and 11 bits for the two 9-bit asynchronous modes. When a character is accepted it is written to the buffer, the received ninth bit is stored, and a receive-done flag is raised for software to clear.

A frame-check enable bit in the option register turns on stop-bit checking. The same bit also decides what the top bit of the control register means. When it is clear, that bit position reads and writes the upper mode-select bit. When it is set, the position reads and writes a sticky framing-error flag instead. The two values are held in separate flip-flops, so changing the enable bit loses neither of them.

Top module: `serial_rx_port`

## Requirements
- R1: After reset, the control register (address 0), the receive buffer (address 1) and the option register (address 2) all read 0x00.
- R2: Control register bits, bit 7 down to bit 0: aliased mode-high/frame-error, mode-low, multiprocessor filter, receive enable, transmit ninth bit, received ninth bit, transmit-done, receive-done. Every bit is writable. The option register stores every written bit except bit 5, which reads 0. Bit 6 of the option register is the frame-check enable.
- R3: In mode 1 (mode bits high,low = 0,1), a 10-bit frame is received: a low start bit, 8 data bits sent LSB first, then a stop bit. On acceptance the buffer holds the data, the received-ninth bit (bit 2) holds the stop bit, and receive-done (bit 0) is set.
- R4: In modes 2 and 3 (mode bits 1,0 and 1,1), an 11-bit frame is received: start bit, 8 data bits LSB first, a ninth data bit, then a stop bit. The ninth data bit is stored in bit 2.
- R5: While receive-done is 1, a completed frame changes neither the buffer nor the received-ninth bit, and receive-done stays 1.
- R6: In modes 2 and 3 with the multiprocessor filter (bit 5) set, a frame whose ninth bit is 0 is discarded. A frame whose ninth bit is 1 is accepted.
- R7: With receive enable (bit 4) clear, or in mode 0 (mode bits 0,0), no reception takes place.
- R8: A start is detected on a high-to-low transition of the line at a tick. If the majority of samples 7, 8 and 9 of the start bit is high, the start is rejected and the receiver returns to idle. The next valid frame is then received correctly.
- R9: When frame checking is enabled and the stop bit is sampled low in modes 1, 2 or 3, the frame-error flag is set. When frame checking is disabled, it is not set.
- R10: Bit 7 of the control register reads and writes the mode-high bit when frame checking is disabled, and the frame-error flag when it is enabled. A write never touches the value that is not selected.
- R11: The frame-error flag is sticky. Hardware only sets it. It is cleared only by writing 0 to bit 7 while frame checking is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxLine | input | 1 | Serial receive line, idle high |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address: 0 control, 1 buffer, 2 option |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data for busAddr, combinational |

## Verification
The hardest state to reach from the ports is a stored mode-high bit and frame-error flag that disagree with each other while the enable bit is switched back and forth. The bench gets there in steps. It first receives a frame with a low stop bit while checking is enabled, which sets the flag. It then switches the enable bit off and on, reading bit 7 each time. Finally it receives another good 10-bit frame without clearing the flag, which shows that the hidden mode bit survived and that the flag stayed set. A second hard case is a short low pulse that looks like a start bit. The bench drives it for only three ticks and then checks that a following frame still lands aligned.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeVote;   // store one of the two early vote samples
    logic decide;     // third vote sample: bit value is valid
    logic shiftIn;    // shift the decided bit into the data register
    logic frameEnd;   // decided bit is the stop bit, close the frame
  } rxStrobe_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_t;
endpackage

// File: rtl/serial_rx_control.sv
module serial_rx_control
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       fallEdge,
  input  logic       renEn,
  input  logic       asyncMode,
  input  logic       nineBit,
  input  logic       bitVal,
  output rxStrobe_t  strobe
);
  localparam int CNT_W  = $clog2(OVERSAMPLE);
  localparam int BIT_W  = $clog2(DATA_W + 2);
  localparam int VOTE_B = OVERSAMPLE / 2;
  localparam int VOTE_A = VOTE_B - 1;
  localparam int VOTE_C = VOTE_B + 1;
  localparam int LAST   = OVERSAMPLE - 1;

  rxState_t            state;
  logic [CNT_W-1:0]    sampleCnt;
  logic [BIT_W-1:0]    bitIdx;
  logic [BIT_W-1:0]    stopIdx;
  logic                active;

  assign stopIdx = nineBit ? BIT_W'(DATA_W + 1) : BIT_W'(DATA_W);
  assign active  = tick && (state != RX_IDLE);

  always_comb begin
    strobe = '0;
    if (active) begin
      if (sampleCnt == CNT_W'(VOTE_A) || sampleCnt == CNT_W'(VOTE_B))
        strobe.takeVote = 1'b1;
      if (sampleCnt == CNT_W'(VOTE_C)) begin
        strobe.decide = 1'b1;
        if (state == RX_BITS) begin
          if (bitIdx < stopIdx) strobe.shiftIn  = 1'b1;
          else                  strobe.frameEnd = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      sampleCnt <= '0;
      bitIdx    <= '0;
    end else if (tick) begin
      if (state == RX_IDLE) begin
        if (fallEdge && renEn && asyncMode) begin
          state     <= RX_START;
          sampleCnt <= CNT_W'(1);
          bitIdx    <= '0;
        end
      end else begin
        sampleCnt <= (sampleCnt == CNT_W'(LAST)) ? '0 : sampleCnt + 1'b1;
        if (sampleCnt == CNT_W'(VOTE_C)) begin
          if (state == RX_START && bitVal)        state <= RX_IDLE;
          if (state == RX_BITS && bitIdx == stopIdx) state <= RX_IDLE;
        end
        if (sampleCnt == CNT_W'(LAST)) begin
          if (state == RX_START) begin
            state  <= RX_BITS;
            bitIdx <= '0;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE && !(renEn && asyncMode)) |=> (state == RX_IDLE));

  // R8
  start_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && strobe.decide && bitVal) |=> (state == RX_IDLE));
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             rxLine,
  input  logic             busWe,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWData,
  output logic [BUS_W-1:0] busRData,
  input  rxStrobe_t        strobe,
  output logic             fallEdge,
  output logic             renEn,
  output logic             asyncMode,
  output logic             nineBit,
  output logic             bitVal
);
  localparam logic [BUS_W-1:0] OPT_MASK = ~(BUS_W'(1) << 5);

  logic              rxMeta, rxSync, rxPrev;
  logic [1:0]        votes;
  logic [DATA_W:0]   shReg;
  logic [DATA_W-1:0] rxBuf, dataOut;
  logic [BUS_W-1:0]  optQ;
  logic modeHiQ, frameErrQ, modeLoQ, multiProcQ, rxEnableQ;
  logic txNinthQ, rxNinthQ, txDoneQ, rxDoneQ;
  logic feDetectEn, ctrlWr, optWr, ninthRx, accept, feSet;

  assign feDetectEn = optQ[6];
  assign ctrlWr     = busWe && busAddr == 2'd0;
  assign optWr      = busWe && busAddr == 2'd2;
  assign renEn      = rxEnableQ;
  assign asyncMode  = modeHiQ || modeLoQ;
  assign nineBit    = modeHiQ;
  assign fallEdge   = tick && rxPrev && !rxSync;
  assign bitVal     = (votes[0] & votes[1]) | (votes[0] & rxSync) | (votes[1] & rxSync);
  assign ninthRx    = shReg[DATA_W];
  assign dataOut    = nineBit ? shReg[DATA_W-1:0] : shReg[DATA_W:1];
  assign accept     = strobe.frameEnd && !rxDoneQ && (!nineBit || !multiProcQ || ninthRx);
  assign feSet      = strobe.frameEnd && feDetectEn && !bitVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
      votes  <= '0;
      shReg  <= '0;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      if (tick)            rxPrev <= rxSync;
      if (strobe.takeVote) votes  <= {votes[0], rxSync};
      if (strobe.shiftIn)  shReg  <= {bitVal, shReg[DATA_W:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {modeHiQ, frameErrQ, modeLoQ, multiProcQ, rxEnableQ} <= '0;
      {txNinthQ, rxNinthQ, txDoneQ, rxDoneQ} <= '0;
      optQ  <= '0;
      rxBuf <= '0;
    end else begin
      if (optWr) optQ <= busWData & OPT_MASK;
      if (ctrlWr) begin
        if (feDetectEn) frameErrQ <= busWData[7];
        else            modeHiQ   <= busWData[7];
        modeLoQ    <= busWData[6];
        multiProcQ <= busWData[5];
        rxEnableQ  <= busWData[4];
        txNinthQ   <= busWData[3];
        rxNinthQ   <= busWData[2];
        txDoneQ    <= busWData[1];
        rxDoneQ    <= busWData[0];
      end
      if (feSet) frameErrQ <= 1'b1;
      if (accept) begin
        rxBuf    <= dataOut;
        rxNinthQ <= nineBit ? ninthRx : bitVal;
        rxDoneQ  <= 1'b1;
      end
    end
  end

  always_comb begin
    case (busAddr)
      2'd0:    busRData = {feDetectEn ? frameErrQ : modeHiQ, modeLoQ, multiProcQ,
                           rxEnableQ, txNinthQ, rxNinthQ, txDoneQ, rxDoneQ};
      2'd1:    busRData = BUS_W'(rxBuf);
      2'd2:    busRData = optQ;
      default: busRData = '0;
    endcase
  end

  // R3
  ri_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDoneQ) |-> $past(strobe.frameEnd || ctrlWr));

  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneQ |=> $stable(rxBuf));

  // R9
  fe_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErrQ) |-> $past(feDetectEn));

  // R10
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlWr && !feDetectEn) |=> $stable(modeHiQ));

  // R11
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameErrQ && !(ctrlWr && feDetectEn && !busWData[7])) |=> frameErrQ);
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxLine,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWData,
  output logic [7:0] busRData
);
  rxStrobe_t strobe;
  logic fallEdge, renEn, asyncMode, nineBit, bitVal;

  serial_rx_control #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) ctrlU (
    .clk(clk), .rstN(rstN), .tick(tick16), .fallEdge(fallEdge), .renEn(renEn),
    .asyncMode(asyncMode), .nineBit(nineBit), .bitVal(bitVal), .strobe(strobe));

  serial_rx_datapath #(.DATA_W(DATA_W), .BUS_W(8)) dpU (
    .clk(clk), .rstN(rstN), .tick(tick16), .rxLine(rxLine), .busWe(busWe),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData), .strobe(strobe),
    .fallEdge(fallEdge), .renEn(renEn), .asyncMode(asyncMode), .nineBit(nineBit),
    .bitVal(bitVal));
endmodule

// File: tb/serial_rx_port_test.sv
`timescale 1ns/1ps
module serial_rx_port_test;
  logic clk = 1'b0, rstN = 1'b0, rxLine = 1'b1, busWe = 1'b0;
  logic [1:0] busAddr = 2'd0, tickCnt;
  logic [7:0] busWData = 8'h00, busRData;
  logic tick16;
  int compared = 0, mismatched = 0;
  bit finished = 0, monBusy = 0;
  string tagQ[$];
  logic [7:0] ctrlQ[$], bufQ[$];

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) tickCnt <= '0; else tickCnt <= tickCnt + 1'b1;
  assign tick16 = (tickCnt == 2'd3);

  serial_rx_port uut (.clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .busWe(busWe), .busAddr(busAddr), .busWData(busWData), .busRData(busRData));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWData = d;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; #1; d = busRData;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); rxLine = b;
    repeat (63) @(negedge clk);
  endtask

  task automatic sendFrame(input bit nine, input logic [7:0] d, input logic b9, input logic stopB);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    if (nine) sendBit(b9);
    sendBit(stopB);
    sendBit(1'b1);
    sendBit(1'b1);
  endtask

  // driver side: push expectation and wait until the monitor compared it
  task automatic expectRegs(input string tag, input logic [7:0] c, input logic [7:0] b);
    ctrlQ.push_back(c);
    bufQ.push_back(b);
    tagQ.push_back(tag);
    wait (tagQ.size() == 0);
    wait (monBusy == 1'b0);
  endtask

  // monitor: pops expectations, reads the design through the bus
  initial begin
    forever begin
      logic [7:0] v, ec, eb;
      string t;
      wait (tagQ.size() > 0);
      monBusy = 1'b1;
      ec = ctrlQ.pop_front();
      eb = bufQ.pop_front();
      t  = tagQ.pop_front();
      rdReg(2'd0, v); check({t, " control"}, v, ec);
      rdReg(2'd1, v); check({t, " buffer"}, v, eb);
      monBusy = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    expectRegs("R1 reset", 8'h00, 8'h00);
    rdReg(2'd2, v); check("R1 option reset", v, 8'h00);

    // R3 mode 1 frame
    wrReg(2'd0, 8'h50);
    sendFrame(0, 8'hA5, 1'b0, 1'b1);
    expectRegs("R3 mode1 frame", 8'h55, 8'hA5);

    // R5 frame ignored while receive-done set
    sendFrame(0, 8'h3C, 1'b0, 1'b1);
    expectRegs("R5 done still set", 8'h55, 8'hA5);

    // R9 low stop with checking disabled: no error flag
    wrReg(2'd0, 8'h50);
    sendFrame(0, 8'h5A, 1'b0, 1'b0);
    expectRegs("R9 check off", 8'h51, 8'h5A);
    wrReg(2'd2, 8'h40);
    rdReg(2'd0, v); check("R9 flag stays clear", v, 8'h51);

    // R9 low stop with checking enabled
    wrReg(2'd0, 8'h50);
    sendFrame(0, 8'h3C, 1'b0, 1'b0);
    expectRegs("R9 frame error", 8'hD1, 8'h3C);

    // R10 alias follows enable bit; R11 flag survives the toggle
    wrReg(2'd2, 8'h00);
    rdReg(2'd0, v); check("R10 mode bit shown", v, 8'h51);
    wrReg(2'd2, 8'h40);
    rdReg(2'd0, v); check("R11 flag kept", v, 8'hD1);

    // R10/R11: hidden mode bit intact, flag sticky over a good frame
    wrReg(2'd0, 8'hD0);
    sendFrame(0, 8'h11, 1'b0, 1'b1);
    expectRegs("R11 sticky over good frame", 8'hD5, 8'h11);
    wrReg(2'd0, 8'h50);
    expectRegs("R11 software clear", 8'h50, 8'h11);

    // R4 mode 3 frames
    wrReg(2'd2, 8'h00);
    wrReg(2'd0, 8'hD0);
    sendFrame(1, 8'h96, 1'b1, 1'b1);
    expectRegs("R4 mode3 ninth one", 8'hD5, 8'h96);
    wrReg(2'd0, 8'hD0);
    sendFrame(1, 8'h69, 1'b0, 1'b1);
    expectRegs("R4 mode3 ninth zero", 8'hD1, 8'h69);

    // R6 multiprocessor filter in mode 2
    wrReg(2'd0, 8'hB0);
    sendFrame(1, 8'h33, 1'b0, 1'b1);
    expectRegs("R6 filtered", 8'hB0, 8'h69);
    sendFrame(1, 8'h21, 1'b1, 1'b1);
    expectRegs("R6 passed", 8'hB5, 8'h21);

    // R9/R10 frame error in mode 3, bit 7 write hits the flag only
    wrReg(2'd2, 8'h40);
    wrReg(2'd0, 8'h50);
    sendFrame(1, 8'hC3, 1'b1, 1'b0);
    expectRegs("R9 mode3 frame error", 8'hD5, 8'hC3);

    // R7 receiver disabled, and mode 0
    wrReg(2'd2, 8'h00);
    wrReg(2'd0, 8'h40);
    sendFrame(0, 8'h77, 1'b0, 1'b1);
    expectRegs("R7 enable clear", 8'h40, 8'hC3);
    wrReg(2'd0, 8'h10);
    sendFrame(0, 8'h77, 1'b0, 1'b1);
    expectRegs("R7 mode0", 8'h10, 8'hC3);

    // R8 short low pulse rejected, following frame aligned
    wrReg(2'd0, 8'h50);
    @(negedge clk); rxLine = 1'b0;
    repeat (12) @(negedge clk);
    rxLine = 1'b1;
    repeat (160) @(negedge clk);
    expectRegs("R8 glitch rejected", 8'h50, 8'hC3);
    sendFrame(0, 8'hE7, 1'b0, 1'b1);
    expectRegs("R8 next frame aligned", 8'h55, 8'hE7);

    // R2 layout: option bit 5 reads zero, plain control bits writable
    wrReg(2'd2, 8'hFF);
    rdReg(2'd2, v); check("R2 option mask", v, 8'hDF);
    wrReg(2'd0, 8'h0A);
    rdReg(2'd0, v); check("R2 control bits", v, 8'h0A);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule